// File: doc/BRIEF.md
# Synthesizer control and lock-status register

This block is an eight-bit control and status register for an on-chip frequency synthesizer, read and written over a simple single-cycle bus port. Software sets an enable bit and an output-rate select bit. The block then drives the synthesizer enable and a request line that starts the internal RC reference oscillator. It also produces a lock flag. The synthesizer is modelled behaviourally: lock is declared after a parameterised number of reference-clock cycles, counted from pulses on a reference tick input.

An input tells the block whether the synthesizer currently feeds the system clock. While that input is high, the enable is held on whatever software writes. The lock flag is therefore never lost by mistake. Disabling the synthesizer, or changing its rate while it runs, drops the lock flag and restarts the lock interval from zero. The whole register is clocked by the bus clock and uses a synchronous active-low reset.

Top module: `synth_ctl_reg`

## Requirements
- R1: After reset the rate and enable storage and the lock flag are zero. Read data equals 8'h00, or 8'h02 when `sys_src_sel` is high.
- R2: Read data bits 7..3 are always zero, and writing ones to them changes nothing that can be observed.
- R3: Read data bit 2 is the rate select (1 = high rate, 0 = low rate). It is loaded by a write, is visible on `rate_hi` after the write edge, and holds when no write occurs.
- R4: Read data bit 1 is the effective enable. This is the stored enable bit (written through bit 1) ORed with `sys_src_sel`. `synth_en` and `osc_req` both equal it.
- R5: While `sys_src_sel` is high, the enable reads 1 and writing 0 to bit 1 neither drops the enable nor clears the lock flag.
- R6: The lock flag (read bit 0 and `synth_locked`) rises at the clock edge that samples the LOCK_CYCLES-th `ref_tick` seen while the effective enable was already 1. It then stays set while enabled.
- R7: A write that clears bit 1 while `sys_src_sel` is low clears the lock flag right after that edge. The next enable counts from zero.
- R8: A write that changes bit 2 clears the lock flag and restarts the count. A `ref_tick` in the cycle of that write is discarded, even when it would have completed the lock interval.
- R9: Writes to bit 0 are ignored, and the lock flag reads 0 in every cycle in which the effective enable reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle high |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Register read value (combinational) |
| sys_src_sel | input | 1 | High when the synthesizer is the system clock source |
| ref_tick | input | 1 | One pulse per reference-oscillator cycle |
| synth_en | output | 1 | Synthesizer enable |
| osc_req | output | 1 | Request to run the RC reference oscillator |
| rate_hi | output | 1 | Selected output rate, 1 = high |
| synth_locked | output | 1 | Lock flag |

## Verification
Two functions can land on the same edge: the lock counter completing its interval, and a register write that restarts it (a rate change or a disable). The bench steers the tick stream so that the final tick coincides exactly with such a write. The lock flag must then stay low, and a full new interval must be needed afterwards. A per-cycle behavioural model judges every edge of these runs against the pins. Separately, a write of 0 to the enable while the source input is high is issued on a lock-completing tick, and the flag must survive.

// File: rtl/synth_pkg.sv
// Package synth_pkg
// Shared field positions and the register width for the synthesizer
// control register. Bit positions are fixed because software decodes them.
package synth_pkg;
    localparam int unsigned REG_W    = 8;
    localparam int unsigned BIT_LOCK = 0;
    localparam int unsigned BIT_EN   = 1;
    localparam int unsigned BIT_RATE = 2;
    localparam int unsigned FIELD_N  = 3;

    // Stored software-controlled fields
    typedef struct packed {
        logic rate;
        logic en;
    } synth_cfg_t;
endpackage

// File: rtl/synth_cfg_bits.sv
// Module synth_cfg_bits
// Holds the writable rate and enable fields, forms the effective enable
// (forced by the system-source input) and flags writes that must restart
// the lock interval. Assumes one write per cycle and REG_W > FIELD_N.
module synth_cfg_bits
    import synth_pkg::*;
#(
    parameter int unsigned W = REG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         src_forced,
    output synth_cfg_t   cfg,
    output logic         en_eff,
    output logic         restart
);
    logic wr_rate;
    logic wr_en;

    assign wr_rate = wdata[BIT_RATE];
    assign wr_en   = wdata[BIT_EN];

    // Load the writable fields on a bus write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr) begin
            cfg.rate <= wr_rate;
            cfg.en   <= wr_en;
        end
    end

    // Effective enable: software bit or forced by clock-source selection
    always_comb begin
        en_eff = cfg.en | src_forced;
    end

    // Restart request: rate change, or an unforced disable
    always_comb begin
        restart = wr && ((wr_rate != cfg.rate) || (!wr_en && !src_forced));
    end
endmodule

// File: rtl/synth_lock_timer.sv
// Module synth_lock_timer
// Behavioural lock model: counts reference ticks while running and raises
// a sticky lock flag on the LOCK_CYCLES-th tick. Not running or a restart
// request returns it to zero; restart wins over a coincident tick.
// Assumes LOCK_CYCLES >= 1.
module synth_lock_timer #(
    parameter int unsigned LOCK_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    input  logic tick,
    output logic locked
);
    localparam int unsigned CNT_W = (LOCK_CYCLES < 2) ? 1 : $clog2(LOCK_CYCLES);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LOCK_CYCLES - 1);

    logic [CNT_W-1:0] cnt;
    logic             clear;
    logic             done;

    // Zero the model whenever not running or restarting
    always_comb begin
        clear = !run || restart;
        done  = tick && (cnt == LAST);
    end

    // Tick counter and lock flag
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt    <= '0;
            locked <= 1'b0;
        end else if (tick && !locked) begin
            if (done) begin
                locked <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/synth_ctl_reg.sv
// Module synth_ctl_reg
// Control and lock-status register of an on-chip frequency synthesizer.
// Bits: 2 rate select, 1 enable (forced on while the synthesizer is the
// system source), 0 read-only lock flag; the upper bits read zero.
// Assumes a single bus clock, synchronous active-low reset, and a ref_tick
// pulse already synchronised to clk.
module synth_ctl_reg
    import synth_pkg::*;
#(
    parameter int unsigned REG_W_P     = REG_W,
    parameter int unsigned LOCK_CYCLES = 1000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [REG_W_P-1:0] bus_wdata,
    output logic [REG_W_P-1:0] bus_rdata,
    input  logic               sys_src_sel,
    input  logic               ref_tick,
    output logic               synth_en,
    output logic               osc_req,
    output logic               rate_hi,
    output logic               synth_locked
);
    localparam int unsigned RSV_N = REG_W_P - FIELD_N;

    synth_cfg_t cfg;
    logic       en_eff;
    logic       restart;
    logic       lock_raw;

    synth_cfg_bits #(.W(REG_W_P)) u_bits (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (bus_wr),
        .wdata      (bus_wdata),
        .src_forced (sys_src_sel),
        .cfg        (cfg),
        .en_eff     (en_eff),
        .restart    (restart)
    );

    synth_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (en_eff),
        .restart (restart),
        .tick    (ref_tick),
        .locked  (lock_raw)
    );

    // Drive synthesizer controls and mask lock by the live enable
    always_comb begin
        synth_en     = en_eff;
        osc_req      = en_eff;
        rate_hi      = cfg.rate;
        synth_locked = lock_raw & en_eff;
    end

    // Read-back mux: reserved bits forced to zero
    always_comb begin
        bus_rdata           = '0;
        bus_rdata[BIT_RATE] = cfg.rate;
        bus_rdata[BIT_EN]   = en_eff;
        bus_rdata[BIT_LOCK] = synth_locked;
        bus_rdata[REG_W_P-1 -: RSV_N] = '0;
    end
endmodule

// File: rtl/synth_ctl_chk.sv
// Module synth_ctl_chk
// Protocol checks on the synthesizer control register's pins, bound into
// every instance of synth_ctl_reg.
module synth_ctl_chk #(
    parameter int unsigned REG_W_P = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_wr,
    input logic [REG_W_P-1:0] bus_wdata,
    input logic [REG_W_P-1:0] bus_rdata,
    input logic               sys_src_sel,
    input logic               ref_tick,
    input logic               synth_en,
    input logic               osc_req,
    input logic               rate_hi,
    input logic               synth_locked
);
    p_rsv_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[REG_W_P-1:3] == '0);

    p_rate_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(rate_hi));

    p_rate_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |=> rate_hi == $past(bus_wdata[2]));

    p_en_view_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_req == synth_en) && (bus_rdata[1] == synth_en));

    p_forced_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sys_src_sel |-> synth_en);

    p_lock_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(synth_locked) && $stable(synth_en) |-> $past(ref_tick));

    p_lock_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        synth_locked && !bus_wr |=> synth_locked || !synth_en);

    p_disable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && !bus_wdata[1] && !sys_src_sel |=> !synth_locked);

    p_rate_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && (bus_wdata[2] != rate_hi) |=> !synth_locked);

    p_lock_needs_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
        synth_locked |-> synth_en);
endmodule

bind synth_ctl_reg synth_ctl_chk #(.REG_W_P(REG_W_P)) u_chk (.*);

// File: tb/tb_synth_ctl_reg.sv
// Bench for synth_ctl_reg: drives inputs on the falling edge, advances a
// behavioural model on each rising edge and compares all pins after it.
module tb_synth_ctl_reg;
    localparam int LOCKN = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       sys_src_sel = 1'b0;
    logic       ref_tick = 1'b0;
    logic       synth_en, osc_req, rate_hi, synth_locked;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    // Model state
    int m_en = 0, m_rate = 0, m_cnt = 0, m_lock = 0;

    synth_ctl_reg #(.LOCK_CYCLES(LOCKN)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .sys_src_sel(sys_src_sel), .ref_tick(ref_tick),
        .synth_en(synth_en), .osc_req(osc_req), .rate_hi(rate_hi),
        .synth_locked(synth_locked)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Compare every pin with the model
    task automatic compare(input string tag);
        int e_en, e_lock;
        logic [7:0] e_rd;
        e_en   = (m_en != 0 || sys_src_sel) ? 1 : 0;
        e_lock = (m_lock != 0 && e_en != 0) ? 1 : 0;
        e_rd   = 8'((m_rate << 2) | (e_en << 1) | e_lock);
        chk(bus_rdata == e_rd, tag, bus_rdata, e_rd);
        chk(synth_en == e_en[0] && osc_req == e_en[0], tag, {osc_req, synth_en}, {e_en[0], e_en[0]});
        chk(rate_hi == m_rate[0], tag, rate_hi, m_rate);
        chk(synth_locked == e_lock[0], tag, synth_locked, e_lock);
    endtask

    // One bus cycle: drive, let the edge pass, advance model, compare
    task automatic step(input bit wr, input logic [7:0] wd, input bit tk, input string tag);
        int en_old, clr;
        @(negedge clk);
        bus_wr = wr; bus_wdata = wd; ref_tick = tk;
        @(posedge clk);
        en_old = (m_en != 0 || sys_src_sel) ? 1 : 0;
        clr = (en_old == 0) ||
              (wr && ((int'(wd[2]) != m_rate) || (!wd[1] && !sys_src_sel)));
        if (clr != 0) begin
            m_cnt = 0; m_lock = 0;
        end else if (tk && m_lock == 0) begin
            m_cnt++;
            if (m_cnt == LOCKN) m_lock = 1;
        end
        if (wr) begin
            m_en = wd[1]; m_rate = wd[2];
        end
        #1;
        compare(tag);
    endtask

    task automatic do_reset(input bit src);
        @(negedge clk);
        rst_n = 1'b0; sys_src_sel = src; bus_wr = 0; ref_tick = 0;
        repeat (2) @(posedge clk);
        m_en = 0; m_rate = 0; m_cnt = 0; m_lock = 0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(bus_rdata == (src ? 8'h02 : 8'h00), "R1 reset value", bus_rdata, src ? 2 : 0);
        compare("R1");
    endtask

    // Watchdog: a hung run counts as a failure
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            bad++; total++;
            $display("FAIL watchdog: actual=%0d expected<=%0d", cycles, 20000);
            finish_run();
        end
    end

    initial begin
        do_reset(1'b0);

        // R2: reserved bits ignored
        step(1, 8'hF8, 0, "R2");
        chk(bus_rdata == 8'h00, "R2 reserved", bus_rdata, 0);

        // R3: rate select stores and holds
        step(1, 8'h04, 0, "R3");
        chk(rate_hi == 1'b1, "R3 rate high", rate_hi, 1);
        step(0, 8'h00, 0, "R3 hold");
        step(1, 8'h00, 0, "R3");

        // R9: bit 0 not writable
        step(1, 8'h01, 1, "R9");
        chk(bus_rdata[0] == 1'b0, "R9 lock not writable", bus_rdata[0], 0);

        // R4/R6: enable, tick in the enable cycle is not counted
        step(1, 8'h02, 1, "R4");
        chk(osc_req == 1'b1, "R4 oscillator request", osc_req, 1);
        for (int i = 0; i < LOCKN - 1; i++) begin
            step(0, 8'h00, 1, "R6");
            step(0, 8'h00, 0, "R6 gap");
        end
        chk(synth_locked == 1'b0, "R6 not yet locked", synth_locked, 0);
        step(0, 8'h00, 1, "R6");
        chk(synth_locked == 1'b1, "R6 locked on last tick", synth_locked, 1);
        step(0, 8'h00, 1, "R6 sticky");

        // R7: disable clears at once, re-enable counts from zero
        step(1, 8'h00, 1, "R7");
        chk(bus_rdata == 8'h00, "R7 disable clears lock", bus_rdata, 0);
        step(1, 8'h02, 0, "R7");
        for (int i = 0; i < LOCKN - 1; i++) step(0, 8'h00, 1, "R7 recount");
        chk(synth_locked == 1'b0, "R7 count restarted", synth_locked, 0);

        // R8: rate change on the completing tick wins
        step(1, 8'h06, 1, "R8");
        chk(synth_locked == 1'b0, "R8 restart beats final tick", synth_locked, 0);
        for (int i = 0; i < LOCKN - 1; i++) step(0, 8'h00, 1, "R8 recount");
        chk(synth_locked == 1'b0, "R8 full interval needed", synth_locked, 0);
        step(0, 8'h00, 1, "R8");
        chk(synth_locked == 1'b1, "R8 relock", synth_locked, 1);
        step(1, 8'h02, 0, "R8 rate change while locked");
        chk(synth_locked == 1'b0, "R8 lock dropped", synth_locked, 0);

        // R5: forced enable survives a disable write on a completing tick
        @(negedge clk); sys_src_sel = 1'b1;
        for (int i = 0; i < LOCKN - 1; i++) step(0, 8'h00, 1, "R5");
        step(1, 8'h00, 1, "R5");
        chk(bus_rdata == 8'h03, "R5 forced enable keeps lock", bus_rdata, 3);
        step(1, 8'h00, 1, "R5 stays");
        chk(synth_locked == 1'b1, "R5 lock held", synth_locked, 1);

        // R9: source released with enable bit clear drops lock
        @(negedge clk); sys_src_sel = 1'b0;
        #1;
        chk(synth_locked == 1'b0, "R9 lock masked when disabled", synth_locked, 0);
        step(0, 8'h00, 1, "R9");

        // R1: reset with the source input high
        do_reset(1'b1);
        for (int i = 0; i < LOCKN; i++) step(0, 8'h00, 1, "R5 forced from reset");
        chk(synth_locked == 1'b1, "R5 forced lock", synth_locked, 1);

        finish_run();
    end
endmodule